// File: doc/BRIEF.md
# Compare-match interval timer

This block is an up-counting interval timer with three software-visible registers: a control word, a compare value and the live count. While the run bit in the control word is set, the count advances by one on every clock. When the running count equals the compare value, the block emits an interrupt lasting one clock. It then does one of two things. With the restart bit set, it clears the count to zero and keeps running. With the restart bit clear, it clears its own run bit and holds the count. Software therefore sees a finished one-shot as the run bit reading back zero.

Software reaches the registers through a plain write-strobe port. Reads are combinational. The enclosing controller is expected to instantiate two copies. The count width, the address width and whether the interrupt comes from a flop are parameters.

Top module: `cmp_interval_timer`

## Requirements
- R1: After reset, the control, compare and count registers all read zero, the timer is stopped and `irq_o` is low.
- R2: Register select is `bus_addr`: 0 is control, 1 is compare, 2 is count. Address 3, and any address with a bit above bit 1 set, reads zero and ignores writes. In the control word, bit 0 is the run bit and bit 1 is the restart bit. Control bits above bit 1 read zero, and written values there are dropped.
- R3: While running and not at a match, the count rises by exactly one per clock and wraps modulo 2^DATA_W.
- R4: A match is the run bit set while count equals compare. `irq_o` is high in the clock following each match clock and low after any clock without a match.
- R5: On a match with the restart bit set, the count reads zero on the next clock, the run bit stays set, and counting continues from there.
- R6: On a match with the restart bit clear, the run bit reads zero on the next clock and the count holds the compare value.
- R7: With the run bit clear, the count is frozen and no interrupt is produced.
- R8: A software write to the count register wins over the increment and the match reload in the same clock. A software write to the control register wins over the hardware clearing of the run bit.
- R9: With compare and count both zero, setting the run bit gives a match on the first running clock.
- R10: Setting the run bit resumes counting from the value last written to the count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the register selected by `bus_addr` |
| bus_addr | input | ADDR_W | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq_o | output | 1 | One-clock interrupt after each match |

## Verification
The bench builds the timer with DATA_W set to 16 and ADDR_W set to 3, keeping the flopped interrupt. The narrow count puts the wrap from 0xFFFF to zero a few clocks away, so R3 can be checked at the wrap boundary. The extra address bit lets the bench write to an alias of the compare address and confirm that the write is ignored. Each read check also samples `irq_o`, so pulse timing is checked clock by clock against counts the bench works out itself.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CMP  = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_NONE = 2'd3
   } tmr_sel_e;

   // control word: bit 1 restart, bit 0 run
   typedef struct packed {
      logic auto_rst;
      logic run;
   } tmr_ctrl_t;

   localparam int CTRL_BITS = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
   import tmr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sw_we,
   input  tmr_ctrl_t sw_val,
   input  logic      hw_stop,
   output tmr_ctrl_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (sw_we) begin
         q <= sw_val;          // software wins over the one-shot clear
      end else if (hw_stop) begin
         q.run <= 1'b0;
      end
   end

endmodule

// File: rtl/tmr_data_reg.sv
module tmr_data_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we) q <= d;
   end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         auto_rst,
   input  logic [W-1:0] cmp,
   input  logic         sw_we,
   input  logic [W-1:0] sw_val,
   output logic [W-1:0] cnt,
   output logic         hit
);

   logic [W-1:0] cnt_nxt;

   assign hit = run && (cnt == cmp);

   always_comb begin
      if (sw_we)          cnt_nxt = sw_val;
      else if (hit)       cnt_nxt = auto_rst ? '0 : cnt;
      else if (run)       cnt_nxt = cnt + W'(1);
      else                cnt_nxt = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

endmodule

// File: rtl/tmr_pulse_out.sv
module tmr_pulse_out #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic irq
);

   generate
      if (REGISTERED) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= hit;
         end
         assign irq = irq_q;
      end else begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = hit;
      end
   endgenerate

endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 2,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   localparam int SEL_W = 2;

   generate
      if (DATA_W < CTRL_BITS) begin : g_bad_width
         $error("DATA_W must hold the control word");
      end
      if (ADDR_W < SEL_W) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   tmr_sel_e          sel;
   logic              addr_ok;
   tmr_ctrl_t         ctrl_q;
   tmr_ctrl_t         ctrl_wr;
   logic [DATA_W-1:0] cmp_q;
   logic [DATA_W-1:0] cnt_q;
   logic              hit;

   assign addr_ok = (bus_addr >> SEL_W) == '0;
   assign sel     = addr_ok ? tmr_sel_e'(bus_addr[SEL_W-1:0]) : SEL_NONE;
   assign ctrl_wr = tmr_ctrl_t'(bus_wdata[CTRL_BITS-1:0]);

   tmr_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_we   (bus_we && sel == SEL_CTRL),
      .sw_val  (ctrl_wr),
      .hw_stop (hit && !ctrl_q.auto_rst),
      .q       (ctrl_q)
   );

   tmr_data_reg #(.W(DATA_W)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we && sel == SEL_CMP),
      .d     (bus_wdata),
      .q     (cmp_q)
   );

   tmr_count_core #(.W(DATA_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q.run),
      .auto_rst (ctrl_q.auto_rst),
      .cmp      (cmp_q),
      .sw_we    (bus_we && sel == SEL_CNT),
      .sw_val   (bus_wdata),
      .cnt      (cnt_q),
      .hit      (hit)
   );

   tmr_pulse_out #(.REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .irq   (irq_o)
   );

   always_comb begin
      case (sel)
         SEL_CTRL: bus_rdata = DATA_W'(ctrl_q);
         SEL_CMP:  bus_rdata = cmp_q;
         SEL_CNT:  bus_rdata = cnt_q;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
   parameter int W       = 32,
   parameter int ADDR_W  = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [W-1:0]      bus_wdata,
   input logic [1:0]        ctrl,
   input logic [W-1:0]      cmp,
   input logic [W-1:0]      cnt,
   input logic              irq
);

   logic run, auto, match, ctrl_we, cnt_we;
   assign run     = ctrl[0];
   assign auto    = ctrl[1];
   assign match   = run && (cnt == cmp);
   assign ctrl_we = bus_we && (bus_addr == ADDR_W'(0));
   assign cnt_we  = bus_we && (bus_addr == ADDR_W'(2));

   a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      run && !match && !cnt_we |=> cnt == W'($past(cnt) + W'(1)));

   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !cnt_we |=> $stable(cnt));

   a_r5_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
      match && auto && !cnt_we |=> cnt == '0);

   a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      match && !auto && !ctrl_we |=> !ctrl[0]);

   a_r6_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      match && !auto && !cnt_we |=> $stable(cnt));

   a_r8_sw_count_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> cnt == $past(bus_wdata));

   generate
      if (IRQ_REG) begin : g_irq_chk
         a_r4_irq_after_match: assert property (@(posedge clk) disable iff (!rst_n)
            match |=> irq);
         a_r4_no_stray_irq: assert property (@(posedge clk) disable iff (!rst_n)
            !match |=> !irq);
      end
   endgenerate

endmodule

bind cmp_interval_timer tmr_chk #(
   .W       (DATA_W),
   .ADDR_W  (ADDR_W),
   .IRQ_REG (IRQ_REGISTERED)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ctrl      (ctrl_q),
   .cmp       (cmp_q),
   .cnt       (cnt_q),
   .irq       (irq_o)
);

// File: tb/sim_cmp_interval_timer.sv
`timescale 1ns/1ps
module sim_cmp_interval_timer;

   localparam int DW = 16;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_o;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [DW-1:0] exp_d;
      bit            exp_irq;
      string         tag;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   cmp_interval_timer #(.DATA_W(DW), .ADDR_W(AW), .IRQ_REGISTERED(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // driver: one clock per call, called at a falling edge
   task automatic wr(input int a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d[DW-1:0];
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [31:0] d, input bit irq, input string tag);
      item_t it;
      bus_addr = AW'(a);
      it.exp_d = d[DW-1:0]; it.exp_irq = irq; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
   endtask

   // monitor: compares one queued item per clock, away from the rising edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (bus_rdata !== it.exp_d || irq_o !== it.exp_irq) begin
               bad++;
               $display("FAIL %s: rdata=%h irq=%0b expected rdata=%h irq=%0b",
                        it.tag, bus_rdata, irq_o, it.exp_d, it.exp_irq);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk(0, 0, 0, "R1 ctrl");
      rd_chk(1, 0, 0, "R1 cmp");
      rd_chk(2, 0, 0, "R1 cnt");

      // R2 map, masking, ignored addresses
      wr(1, 32'h1234);
      rd_chk(1, 32'h1234, 0, "R2 cmp readback");
      wr(0, 32'hFFFC);
      rd_chk(0, 0, 0, "R2 ctrl upper bits dropped");
      wr(3, 32'h5555);
      wr(5, 32'h0F0F);
      rd_chk(1, 32'h1234, 0, "R2 alias write ignored");
      rd_chk(3, 0, 0, "R2 addr3 reads zero");
      rd_chk(5, 0, 0, "R2 high addr reads zero");
      wr(2, 5);
      // R7 stopped count frozen
      rd_chk(2, 5, 0, "R7 frozen a");
      rd_chk(2, 5, 0, "R7 frozen b");

      // R10 / R3 counting from written value
      wr(1, 100);
      wr(2, 10);
      wr(0, 1);
      rd_chk(2, 10, 0, "R10 resume value");
      rd_chk(2, 11, 0, "R3 step 1");
      rd_chk(2, 12, 0, "R3 step 2");
      wr(0, 0);              // count 13 here, one last increment
      rd_chk(2, 14, 0, "R7 stop a");
      rd_chk(2, 14, 0, "R7 stop b");

      // R6 one-shot with R4 pulse timing
      wr(2, 0); wr(1, 3); wr(0, 1);
      rd_chk(2, 0, 0, "R6 os c0");
      rd_chk(2, 1, 0, "R6 os c1");
      rd_chk(2, 2, 0, "R6 os c2");
      rd_chk(2, 3, 0, "R4 match cycle no irq yet");
      rd_chk(0, 0, 1, "R6 run cleared, R4 pulse");
      rd_chk(2, 3, 0, "R6 count held, R4 pulse ended");
      rd_chk(2, 3, 0, "R6 still stopped");

      // R5 restart mode
      wr(2, 0); wr(1, 2); wr(0, 3);
      rd_chk(2, 0, 0, "R5 c0");
      rd_chk(2, 1, 0, "R5 c1");
      rd_chk(2, 2, 0, "R5 match");
      rd_chk(2, 0, 1, "R5 reload zero");
      rd_chk(2, 1, 0, "R5 c1 again");
      rd_chk(2, 2, 0, "R5 match again");
      rd_chk(0, 3, 1, "R5 run kept");
      wr(0, 0);

      // R9 compare zero
      wr(2, 0); wr(1, 0); wr(0, 1);
      rd_chk(2, 0, 0, "R9 first running clock");
      rd_chk(0, 0, 1, "R9 immediate pulse");

      // R8 count write wins over reload
      wr(2, 0); wr(1, 2); wr(0, 3);
      rd_chk(2, 0, 0, "R8 c0");
      rd_chk(2, 1, 0, "R8 c1");
      wr(2, 7);              // match clock
      rd_chk(2, 7, 1, "R8 sw count wins");
      rd_chk(2, 8, 0, "R8 continues");
      wr(0, 0);

      // R8 control write wins over one-shot clear
      wr(2, 0); wr(1, 1); wr(0, 1);
      rd_chk(2, 0, 0, "R8 os c0");
      wr(0, 1);              // match clock
      rd_chk(0, 1, 1, "R8 sw ctrl wins");
      rd_chk(2, 1, 1, "R8 second match pulse");
      rd_chk(0, 0, 0, "R8 run cleared after");

      // R3 wrap
      wr(1, 1); wr(2, 32'hFFFE); wr(0, 1);
      rd_chk(2, 32'hFFFE, 0, "R3 wrap a");
      rd_chk(2, 32'hFFFF, 0, "R3 wrap b");
      rd_chk(2, 0, 0, "R3 wrapped");
      rd_chk(2, 1, 0, "R3 match after wrap");
      rd_chk(0, 0, 1, "R3 pulse after wrap");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule